// File: doc/BRIEF.md
# Gate-Built Ternary Match Array

This block is a small ternary content-addressable memory made only of flip-flops and logic gates. Every row holds a stored word and a per-bit mask word. A mask bit of 1 turns that bit position into a don't-care. When a search is launched, one key is presented to all rows at the same time. Each row reports a match line, and a priority stage reduces the match lines to a hit flag and the index of the lowest-numbered matching row.

Entries are loaded one row per clock through a synchronous write port. Loading a row also marks it as occupied. A row that has never been loaded since reset cannot match. The search result, including the raw match-line vector, is registered and appears one clock after the key is applied. The row count and word width are parameters, with a default of four rows of four bits.

Top module: `tcam_gate_array`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `res_hit`, `res_idx` and `res_lines` are all 0.
- R2: With `wr_en` high at a rising edge, `wr_data` and `wr_mask` are stored in row `wr_addr` in that single clock, and the row becomes occupied.
- R3: For a stored bit whose mask bit is 1, either key value matches. For a stored bit whose mask bit is 0, the key bit must equal the stored bit.
- R4: Bit r of `res_lines` is 1 exactly when row r is occupied and every bit position of row r matches the key under R3.
- R5: When several rows match, `res_hit` is 1 and `res_idx` gives the lowest-numbered matching row.
- R6: When no row matches, `res_hit` is 0 and `res_idx` is 0.
- R7: When `srch_valid` is high at a rising edge, the result for `srch_key` appears after that edge, and `res_valid` is 1 for exactly that cycle.
- R8: When `srch_valid` is low at a rising edge, `res_valid` becomes 0 and `res_hit`, `res_idx` and `res_lines` keep their previous values.
- R9: A search launched in the same cycle as a write is compared against the row contents from before that write. The next search sees the new contents.
- R10: A row that has not been written since reset never sets its match line, whatever its mask or the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load one row this cycle |
| wr_addr | input | IDX_W | Row to load |
| wr_data | input | WIDTH | Value bits for the row |
| wr_mask | input | WIDTH | Don't-care bits for the row (1 = ignore) |
| srch_valid | input | 1 | Launch a search this cycle |
| srch_key | input | WIDTH | Search key |
| res_valid | output | 1 | Result registers were updated by the last edge |
| res_hit | output | 1 | At least one row matched |
| res_idx | output | IDX_W | Lowest matching row |
| res_lines | output | ROWS | Registered match line of every row |

## Verification
A write and a search can occur in the same clock. The bench drives a row write together with a search whose key matches only the old contents of that row. The expected result is the hit on that row from before the write. A second search in the next cycle must then show the row matching only the new word. Every other search is judged against a bench model. The model applies writes only after it has computed the expected result for the search in the same cycle, and it sweeps all keys over several table contents.

// File: rtl/tcam_pkg.sv
// Package: shared helpers for the gate-built ternary match array.
// Assumes: row counts of one or more; widths are plain parameters.
package tcam_pkg;

    // Width of a row index; at least one bit even for a single row.
    function automatic int idx_width(input int rows);
        return (rows < 2) ? 1 : $clog2(rows);
    endfunction

endpackage

// File: rtl/tcam_cell.sv
// Module: one ternary cell. It holds a value flip-flop and a mask flip-flop,
// and it produces one encoded bit that is 1 when the key bit is accepted.
// Assumes: load is a one-hot row select that is already qualified by write enable.
module tcam_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic wr_bit,
    input  logic wr_dc,
    input  logic key_bit,
    output logic enc_bit
);
    logic val_q;
    logic dc_q;
    logic eq;

    // Storage: load the value and don't-care flip-flops on a row write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            dc_q  <= 1'b0;
        end else if (load) begin
            val_q <= wr_bit;
            dc_q  <= wr_dc;
        end
    end

    // Compare: XNOR against the key, then OR with the don't-care bit.
    always_comb begin
        eq      = ~(val_q ^ key_bit);
        enc_bit = dc_q | eq;
    end

endmodule

// File: rtl/tcam_row.sv
// Module: one row of ternary cells plus its occupied flag; drives the match line.
// Assumes: key is held stable over the cycle; load selects this row only.
module tcam_row #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic [WIDTH-1:0] key,
    output logic             match
);
    logic [WIDTH-1:0] enc;
    logic             used_q;

    // One cell per column; key bit k drives column k.
    for (genvar k = 0; k < WIDTH; k++) begin : g_col
        tcam_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .wr_bit (wr_data[k]),
            .wr_dc  (wr_mask[k]),
            .key_bit(key[k]),
            .enc_bit(enc[k])
        );
    end

    // Occupied flag: cleared by reset, set by the first write to this row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
        end else if (load) begin
            used_q <= 1'b1;
        end
    end

    // Match line: AND of all encoded bits, gated by the occupied flag.
    always_comb begin
        match = used_q & (&enc);
    end

endmodule

// File: rtl/tcam_prio.sv
// Module: priority encoder over the match lines; the lowest index wins.
// Assumes: IDX_W bits are enough to index ROWS rows.
module tcam_prio #(
    parameter int ROWS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [ROWS-1:0]  lines,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top row down so the lowest set line is assigned last.
    always_comb begin
        any = |lines;
        idx = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (lines[r]) begin
                idx = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/tcam_gate_array.sv
// Module: top of the gate-built ternary match array. It decodes the write port,
// holds ROWS rows, and registers the prioritised search result one clock after the key.
// Assumes: a search and a write in the same cycle see the contents from before the write.
module tcam_gate_array #(
    parameter int ROWS  = 4,
    parameter int WIDTH = 4,
    parameter int IDX_W = tcam_pkg::idx_width(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic             srch_valid,
    input  logic [WIDTH-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [ROWS-1:0]  res_lines
);
    logic [ROWS-1:0]  row_load;
    logic [ROWS-1:0]  lines;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;

    // Write decoder and rows: each row compares its own index against the address.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_load[r] = wr_en && (wr_addr == IDX_W'(r));

        tcam_row #(.WIDTH(WIDTH)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (row_load[r]),
            .wr_data(wr_data),
            .wr_mask(wr_mask),
            .key    (srch_key),
            .match  (lines[r])
        );
    end

    tcam_prio #(.ROWS(ROWS), .IDX_W(IDX_W)) u_prio (
        .lines(lines),
        .any  (any_hit),
        .idx  (win_idx)
    );

    // Result stage: capture on a search; otherwise hold and drop the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_lines <= '0;
        end else if (srch_valid) begin
            res_valid <= 1'b1;
            res_hit   <= any_hit;
            res_idx   <= win_idx;
            res_lines <= lines;
        end else begin
            res_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tcam_gate_array_chk.sv
// Module: assertion checker for tcam_gate_array, attached by bind.
// Assumes: the same parameters as the instance it is bound to.
module tcam_gate_array_chk #(
    parameter int ROWS  = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [ROWS-1:0]  res_lines
);
    // R1: the first cycle out of reset shows an empty result.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!res_valid && !res_hit && res_idx == '0 && res_lines == '0));

    // R7: the valid flag follows a launched search by one clock.
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> res_valid);

    // R8: without a search, the valid flag drops and the result holds.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> (!res_valid && $stable(res_hit) && $stable(res_idx) && $stable(res_lines)));

    // R5: a reported winner has its own match line set.
    p_winner_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> res_lines[res_idx]);

    // R5: no lower-numbered row also matched.
    p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |->
            ((res_lines & ((ROWS'(1) << res_idx) - ROWS'(1))) == '0));

    // R6: a miss has no lines set and a zero index.
    p_miss_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_lines == '0 && res_idx == '0));

endmodule

bind tcam_gate_array tcam_gate_array_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .srch_valid(srch_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .res_lines (res_lines)
);

// File: tb/tcam_gate_array_bench.sv
// Bench: sweeps every key over several table contents, with a bench-side model.
module tcam_gate_array_bench;
    localparam int ROWS = 4;
    localparam int W    = 4;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  wr_mask = '0;
    logic          srch_valid = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [IW-1:0] res_idx;
    logic [ROWS-1:0] res_lines;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Bench model of the table contents.
    logic [W-1:0] md [ROWS];
    logic [W-1:0] mm [ROWS];
    logic         mv [ROWS];
    // Last expected result, for the hold checks.
    logic          e_hit = 1'b0;
    logic [IW-1:0] e_idx = '0;
    logic [ROWS-1:0] e_lines = '0;

    always #10 clk = ~clk;

    tcam_gate_array #(.ROWS(ROWS), .WIDTH(W)) u_tcam_gate_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .srch_valid(srch_valid),
        .srch_key(srch_key), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx), .res_lines(res_lines)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected lines: a row matches when occupied and no cared bit differs.
    function automatic logic [ROWS-1:0] exp_lines(input logic [W-1:0] k);
        logic [ROWS-1:0] v = '0;
        for (int r = 0; r < ROWS; r++) begin
            v[r] = mv[r] && (((k ^ md[r]) & ~mm[r]) == '0);
        end
        return v;
    endfunction

    // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
    task automatic step(input bit we, input int wa, input logic [W-1:0] wd,
                        input logic [W-1:0] wm, input bit sv, input logic [W-1:0] key,
                        input string tag);
        wr_en = we; wr_addr = IW'(wa); wr_data = wd; wr_mask = wm;
        srch_valid = sv; srch_key = key;
        if (sv) begin
            e_lines = exp_lines(key);
            e_hit = 1'b0;
            e_idx = '0;
            for (int r = 0; r < ROWS; r++) begin
                if (e_lines[r] && !e_hit) begin
                    e_hit = 1'b1;
                    e_idx = IW'(r);
                end
            end
        end
        if (we) begin
            md[wa] = wd; mm[wa] = wm; mv[wa] = 1'b1;
        end
        @(negedge clk);
        check(res_valid == sv, {tag, " R7/R8 valid"}, int'(res_valid), int'(sv));
        check(res_lines == e_lines, {tag, " R4 lines"}, int'(res_lines), int'(e_lines));
        check(res_hit == e_hit, {tag, " R5/R6 hit"}, int'(res_hit), int'(e_hit));
        check(res_idx == e_idx, {tag, " R5/R6 idx"}, int'(res_idx), int'(e_idx));
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < (1 << W); k++) begin
            step(1'b0, 0, '0, '0, 1'b1, W'(k), tag);
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d, input logic [W-1:0] m);
        step(1'b1, a, d, m, 1'b0, '0, "R2 write");
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            md[r] = '0; mm[r] = '0; mv[r] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        check(res_hit == 1'b0, "R1 hit", int'(res_hit), 0);
        check(res_idx == '0, "R1 idx", int'(res_idx), 0);
        check(res_lines == '0, "R1 lines", int'(res_lines), 0);

        // R10: an empty table never matches.
        sweep("R10 empty");

        // R2/R3: exact row, partly masked row, fully masked row; row 3 stays unwritten (R10).
        wr(0, 4'b1010, 4'b0000);
        wr(1, 4'b1000, 4'b0011);
        wr(2, 4'b0000, 4'b1111);
        sweep("R3 cfgA");

        // R8: hold with no search, including across a write.
        step(1'b0, 0, '0, '0, 1'b0, 4'b1111, "R8 hold");
        wr(3, 4'b0111, 4'b0000);
        step(1'b0, 0, '0, '0, 1'b0, 4'b0000, "R8 hold2");

        // R5: overlapping entries for the priority checks.
        wr(2, 4'b0110, 4'b1001);
        sweep("R5 cfgB");

        // R9: write row 0 while searching its old value, then search again.
        wr(0, 4'b1100, 4'b0000);
        wr(1, 4'b0000, 4'b0000);
        step(1'b1, 0, 4'b0011, 4'b0000, 1'b1, 4'b1100, "R9 same-cycle");
        step(1'b0, 0, '0, '0, 1'b1, 4'b1100, "R9 after");
        step(1'b0, 0, '0, '0, 1'b1, 4'b0011, "R9 new");

        // R3/R4/R5: computed table contents, full key sweep each.
        for (int i = 0; i < 12; i++) begin
            for (int r = 0; r < ROWS; r++) begin
                wr(r, W'((i * 7 + r * 3) % 16), W'((i * 5 + r * 9) % 16 & ((i % 3 == 0) ? 4'h0 : 4'hF)));
            end
            sweep("R4 mix");
        end

        step(1'b0, 0, '0, '0, 1'b0, '0, "R8 idle");
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule